// File: doc/BRIEF.md
# Staircase Harmonic-Elimination Gate Sequencer

This block drives one phase of a seven-level inverter built from three series full-bridge cells. It switches at the fundamental frequency only. An internal phase accumulator adds `step` on every clock with `tick` high. The accumulator's top two bits give the quadrant, and the remaining bits give the position inside that quadrant. The position is folded so that the second quarter mirrors the first, and the block then compares it against three programmed switching angles. A cell conducts when the folded position has reached that cell's angle. Its polarity follows the half-cycle: positive in the first half, negative in the second. The result is a staircase that mirrors itself about each quarter point, and each cell's switches change state only at its own angle and that angle's mirror images.

The switching angles are computed off-chip, for example by an iterative solver, so that chosen harmonics cancel. They are given as quarter-cycle thresholds. A write is checked for strictly rising order and held in a shadow copy. The shadow copy goes live only on the tick at which the accumulator wraps, so a fundamental cycle never mixes two angle sets. Each half-bridge leg has a programmable blanking interval. Whenever the leg's commanded state changes, both of its switches are held off for that many clocks. The outputs are twelve gate signals and a signed level code.

Top module: `she_stair_gate`

## Requirements
- R1: After reset the accumulator reads 0, `level` is 0, `ang_err` is 0, every cell is in its zero state (`gate` = 12'h555), and the live angles are 4096, 8192 and 12288 for cells 0, 1 and 2.
- R2: On each clock with `tick` high, `phase` becomes `phase + step` modulo 2^16. The new value is visible in the cycle after that edge.
- R3: With h = `phase` mod 2^15, cell c conducts when A[c] <= h < 2^15 - A[c], where A[c] is the cell's live angle. `level` equals the number of conducting cells. It is positive when `phase[15]` is 0 and negative when `phase[15]` is 1. It is a combinational function of the registered phase and the live angles.
- R4: In the second and fourth quarters (`phase[14]` = 1), the in-quarter position is mirrored. Each step therefore switches off at 2^15 - A[c] measured within the half-cycle.
- R5: Within a cell's four gate bits, bit 0 is the upper-left switch, bit 1 the lower-left, bit 2 the upper-right and bit 3 the lower-right. Positive conduction is 4'b1001, negative conduction is 4'b0110, and zero is 4'b0101. Cell c occupies `gate[4c+3:4c]`.
- R6: When a leg's commanded state changes and `dead_cfg` is D > 0, both switches of that leg read 0 for exactly D clocks. The new state then appears. The blanking starts one clock after the phase update.
- R7: With `dead_cfg` = 0, the gates reach the new state one clock after the phase update.
- R8: A write on `ang_wr` leaves the live angles untouched until a tick whose addition carries out of bit 15. That tick loads them.
- R9: A write whose angles do not rise strictly from cell 0 to cell 2 (equal values included) is discarded and sets `ang_err` one clock later. A later valid write clears it.
- R10: While `tick` is low, `phase` and `level` hold their values, whatever `step` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance enable for the accumulator |
| step | input | 16 | Accumulator increment per tick |
| ang_wr | input | 1 | Write strobe for a new angle set |
| ang_in | input | 42 | Angles, cell 0 in bits 13:0, cell 1 in 27:14, cell 2 in 41:28 |
| dead_cfg | input | 8 | Leg blanking length in clocks |
| phase | output | 16 | Current accumulator value |
| level | output | 3 | Signed staircase level, -3 to +3 |
| gate | output | 12 | Four switch gates per cell |
| ang_err | output | 1 | Last angle write was rejected |

## Verification
`phase` and `level` are due in the cycle that follows the ticking edge, and the bench reads them at the next falling edge after that edge. The gates come one further clock later, plus `dead_cfg` clocks when blanking is on. The bench waits exactly that many falling edges and also samples the blanked window in between. `ang_err` is read one falling edge after the write strobe. An angle change is judged only by the level seen after a tick that wraps the accumulator, compared with the level seen before it.

// File: rtl/she_pkg.sv
package she_pkg;

  // conduction state of one full-bridge cell
  typedef enum logic [1:0] {
    CM_ZERO = 2'd0,
    CM_POS  = 2'd1,
    CM_NEG  = 2'd2
  } cell_mode_e;

  // left leg sits high unless the cell drives negative
  function automatic logic left_leg_high(input cell_mode_e m);
    return m != CM_NEG;
  endfunction

  // right leg sits high unless the cell drives positive
  function automatic logic right_leg_high(input cell_mode_e m);
    return m != CM_POS;
  endfunction

endpackage

// File: rtl/she_phase_acc.sv
module she_phase_acc #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] phase,
  output logic            wrap_evt
);

  logic [PH_W:0] sum;

  assign sum      = {1'b0, phase} + {1'b0, step};
  assign wrap_evt = tick & sum[PH_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= sum[PH_W-1:0];
  end

endmodule

// File: rtl/she_angle_bank.sv
module she_angle_bank #(
  parameter  int ANG_W = 14,
  parameter  int NCELL = 3,
  localparam int VW    = NCELL * ANG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [VW-1:0] ang_in,
  input  logic          apply,
  output logic [VW-1:0] act,
  output logic          err
);

  function automatic logic rising_order(input logic [VW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int c = 1; c < NCELL; c++)
      if (v[c*ANG_W +: ANG_W] <= v[(c-1)*ANG_W +: ANG_W]) ok = 1'b0;
    return ok;
  endfunction

  // evenly spread default steps across the quarter
  function automatic logic [VW-1:0] spread_default();
    logic [VW-1:0] v;
    for (int c = 0; c < NCELL; c++)
      v[c*ANG_W +: ANG_W] = ANG_W'(((c + 1) * (1 << ANG_W)) / (NCELL + 1));
    return v;
  endfunction

  localparam logic [VW-1:0] DEF_ANG = spread_default();

  logic [VW-1:0] shadow;
  logic          pending;
  logic          wr_ok;

  assign wr_ok = rising_order(ang_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= DEF_ANG;
      act     <= DEF_ANG;
      pending <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (apply && pending) begin
        act     <= shadow;
        pending <= 1'b0;
      end
      if (wr) begin
        if (wr_ok) begin
          shadow  <= ang_in;
          pending <= 1'b1;
          err     <= 1'b0;
        end else begin
          err     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/she_level_map.sv
module she_level_map
  import she_pkg::*;
#(
  parameter  int PH_W  = 16,
  parameter  int NCELL = 3,
  localparam int ANG_W = PH_W - 2,
  localparam int LVL_W = $clog2(NCELL + 1) + 1
) (
  input  logic [PH_W-1:0]        phase,
  input  logic [NCELL*ANG_W-1:0] act_ang,
  output cell_mode_e             mode [NCELL],
  output logic signed [LVL_W-1:0] level
);

  // mirror the falling quarter back onto the rising one
  function automatic logic [ANG_W-1:0] fold_quarter(input logic [PH_W-1:0] p);
    return p[PH_W-2] ? ~p[ANG_W-1:0] : p[ANG_W-1:0];
  endfunction

  logic [ANG_W-1:0] pos_q;
  logic             neg_half;
  logic [LVL_W-1:0] n_on;

  assign pos_q    = fold_quarter(phase);
  assign neg_half = phase[PH_W-1];

  always_comb begin
    n_on = '0;
    for (int c = 0; c < NCELL; c++) begin
      if (pos_q >= act_ang[c*ANG_W +: ANG_W]) begin
        mode[c] = neg_half ? CM_NEG : CM_POS;
        n_on    = n_on + {{(LVL_W-1){1'b0}}, 1'b1};
      end else begin
        mode[c] = CM_ZERO;
      end
    end
    level = neg_half ? -$signed(n_on) : $signed(n_on);
  end

endmodule

// File: rtl/she_leg_dt.sv
module she_leg_dt #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want_hi,
  input  logic [DT_W-1:0] dead,
  output logic            hi_on,
  output logic            lo_on
);

  logic            cur;
  logic            blank;
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= 1'b1;
      blank <= 1'b0;
      cnt   <= '0;
    end else if (blank) begin
      if (cnt <= {{(DT_W-1){1'b0}}, 1'b1}) begin
        blank <= 1'b0;
        cur   <= want_hi;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (want_hi != cur) begin
      if (dead == '0) begin
        cur <= want_hi;
      end else begin
        blank <= 1'b1;
        cnt   <= dead;
      end
    end
  end

  assign hi_on = cur & ~blank;
  assign lo_on = ~cur & ~blank;

endmodule

// File: rtl/she_stair_gate.sv
module she_stair_gate
  import she_pkg::*;
#(
  parameter  int PH_W  = 16,
  parameter  int NCELL = 3,
  parameter  int DT_W  = 8,
  localparam int ANG_W = PH_W - 2,
  localparam int LVL_W = $clog2(NCELL + 1) + 1,
  localparam int GW    = 4 * NCELL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [PH_W-1:0]         step,
  input  logic                    ang_wr,
  input  logic [NCELL*ANG_W-1:0]  ang_in,
  input  logic [DT_W-1:0]         dead_cfg,
  output logic [PH_W-1:0]         phase,
  output logic signed [LVL_W-1:0] level,
  output logic [GW-1:0]           gate,
  output logic                    ang_err
);

  logic                   wrap_evt;
  logic [NCELL*ANG_W-1:0] act_ang;
  cell_mode_e             mode [NCELL];

  she_phase_acc #(.PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
    .phase(phase), .wrap_evt(wrap_evt)
  );

  she_angle_bank #(.ANG_W(ANG_W), .NCELL(NCELL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(ang_wr), .ang_in(ang_in),
    .apply(wrap_evt), .act(act_ang), .err(ang_err)
  );

  she_level_map #(.PH_W(PH_W), .NCELL(NCELL)) u_map (
    .phase(phase), .act_ang(act_ang), .mode(mode), .level(level)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic l_want, r_want;
    assign l_want = left_leg_high(mode[c]);
    assign r_want = right_leg_high(mode[c]);

    she_leg_dt #(.DT_W(DT_W)) u_left (
      .clk(clk), .rst_n(rst_n), .want_hi(l_want), .dead(dead_cfg),
      .hi_on(gate[4*c+0]), .lo_on(gate[4*c+1])
    );

    she_leg_dt #(.DT_W(DT_W)) u_right (
      .clk(clk), .rst_n(rst_n), .want_hi(r_want), .dead(dead_cfg),
      .hi_on(gate[4*c+2]), .lo_on(gate[4*c+3])
    );
  end

endmodule

// File: rtl/she_stair_gate_chk.sv
module she_stair_gate_chk #(
  parameter  int PH_W  = 16,
  parameter  int NCELL = 3,
  parameter  int DT_W  = 8,
  localparam int ANG_W = PH_W - 2,
  localparam int LVL_W = $clog2(NCELL + 1) + 1,
  localparam int GW    = 4 * NCELL
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    ang_wr,
  input logic [NCELL*ANG_W-1:0]  ang_in,
  input logic                    ang_err,
  input logic                    wrap_evt,
  input logic [NCELL*ANG_W-1:0]  act_ang,
  input logic [PH_W-1:0]         phase,
  input logic signed [LVL_W-1:0] level,
  input logic [GW-1:0]           gate,
  input logic [DT_W-1:0]         dead_cfg
);

  logic bad_set;
  always_comb begin
    bad_set = 1'b0;
    for (int c = 1; c < NCELL; c++)
      if (!(ang_in[(c-1)*ANG_W +: ANG_W] < ang_in[c*ANG_W +: ANG_W])) bad_set = 1'b1;
  end

  AST_BAD_SET_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ang_wr && bad_set) |=> ang_err); // R9

  AST_ANGLES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(act_ang)); // R8

  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(level) && $stable(phase))); // R10

  AST_POS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[PH_W-1] |-> level >= 0); // R3

  AST_NEG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PH_W-1] |-> level <= 0); // R3

  for (genvar l = 0; l < 2 * NCELL; l++) begin : g_leg
    AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dead_cfg) != '0 && $rose(gate[2*l])) |-> $past(gate[2*l+1 -: 2]) == 2'b00); // R6
    AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dead_cfg) != '0 && $rose(gate[2*l+1])) |-> $past(gate[2*l+1 -: 2]) == 2'b00); // R6
  end

endmodule

bind she_stair_gate she_stair_gate_chk #(.PH_W(PH_W), .NCELL(NCELL), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ang_wr(ang_wr), .ang_in(ang_in),
  .ang_err(ang_err), .wrap_evt(wrap_evt), .act_ang(act_ang), .phase(phase),
  .level(level), .gate(gate), .dead_cfg(dead_cfg)
);

// File: tb/sim_she_stair_gate.sv
module sim_she_stair_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] step = '0;
  logic        ang_wr = 1'b0;
  logic [41:0] ang_in = '0;
  logic [7:0]  dead_cfg = '0;
  logic [15:0] phase;
  logic signed [2:0] level;
  logic [11:0] gate;
  logic        ang_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  she_stair_gate u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .ang_wr(ang_wr),
    .ang_in(ang_in), .dead_cfg(dead_cfg), .phase(phase), .level(level),
    .gate(gate), .ang_err(ang_err)
  );

  // phase stimulus and expected level for the reset angles 4096/8192/12288
  localparam int NV = 22;
  localparam int VPH [NV] = '{0, 4095, 4096, 8191, 8192, 12288, 16383, 16384,
                              20479, 20480, 24575, 24576, 28671, 28672, 32767,
                              32768, 36864, 45056, 53248, 61440, 61439, 65535};
  localparam int VLV [NV] = '{0, 0, 1, 1, 2, 3, 3, 3,
                              3, 2, 2, 1, 1, 0, 0,
                              0, -1, -3, -2, 0, -1, 0};

  // expected level from the half-cycle window rule
  function automatic int ref_level(input int p, input int a0, input int a1, input int a2);
    int h, n;
    h = p % 32768;
    n = 0;
    if (h >= a0 && h < 32768 - a0) n++;
    if (h >= a1 && h < 32768 - a1) n++;
    if (h >= a2 && h < 32768 - a2) n++;
    return (p >= 32768) ? -n : n;
  endfunction

  function automatic int ref_gates(input int lv);
    int g, mag;
    g = 0;
    mag = (lv < 0) ? -lv : lv;
    for (int c = 0; c < 3; c++) begin
      if (c < mag) g |= ((lv > 0) ? 4'b1001 : 4'b0110) << (4 * c);
      else         g |= 4'b0101 << (4 * c);
    end
    return g;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic go_to(input int p);
    @(negedge clk);
    step = 16'(p) - phase;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic write_angles(input int a0, input int a1, input int a2);
    @(negedge clk);
    ang_in = {14'(a2), 14'(a1), 14'(a0)};
    ang_wr = 1'b1;
    @(negedge clk);
    ang_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 gate", int'(gate), 12'h555);
    chk("R1 err", int'(ang_err), 0);
    rst_n = 1'b1;

    // R3/R4/R5/R7: table walk with no blanking
    for (int i = 0; i < NV; i++) begin
      go_to(VPH[i]);
      chk("R2 phase", int'(phase), VPH[i]);
      chk(((VPH[i] / 16384) % 2 == 1) ? "R4 level" : "R3 level", int'(level), VLV[i]);
      chk("R3 rule", VLV[i], ref_level(VPH[i], 4096, 8192, 12288));
      @(negedge clk);
      chk("R7 gate", int'(gate), ref_gates(VLV[i]));
      chk("R5 gate", int'(gate), ref_gates(int'(level)));
    end

    // R2: modular wrap
    go_to(65535);
    @(negedge clk);
    step = 16'd3;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R2 wrap", int'(phase), 2);

    // R10: no tick, nonzero step
    go_to(12288);
    step = 16'd1000;
    repeat (5) @(negedge clk);
    chk("R10 phase", int'(phase), 12288);
    chk("R10 level", int'(level), 3);

    // R6: blanking of five clocks
    go_to(0);
    dead_cfg = 8'd5;
    repeat (8) @(negedge clk);
    chk("R6 settled", int'(gate), 12'h555);
    go_to(4096);
    chk("R6 pre", int'(gate), 12'h555);
    @(negedge clk);
    chk("R6 blank first", int'(gate), 12'h551);
    repeat (4) @(negedge clk);
    chk("R6 blank last", int'(gate), 12'h551);
    @(negedge clk);
    chk("R6 after", int'(gate), 12'h559);
    dead_cfg = 8'd0;

    // R8: angles wait for the wrapping tick
    go_to(4000);
    chk("R8 old", int'(level), 0);
    write_angles(1000, 3000, 5000);
    chk("R9 ok", int'(ang_err), 0);
    go_to(4000);
    chk("R8 held", int'(level), 0);
    go_to(65535);
    go_to(4000);
    chk("R8 applied", int'(level), ref_level(4000, 1000, 3000, 5000));

    // R9: disordered and equal sets are rejected
    write_angles(5000, 3000, 7000);
    chk("R9 flag", int'(ang_err), 1);
    go_to(65535);
    go_to(6000);
    chk("R9 kept", int'(level), 3);
    write_angles(3000, 3000, 7000);
    chk("R9 equal", int'(ang_err), 1);
    write_angles(4096, 8192, 12288);
    chk("R9 cleared", int'(ang_err), 0);
    go_to(65535);
    go_to(6000);
    chk("R9 reload", int'(level), 1);

    summary();
    $finish;
  end

endmodule